// File: doc/BRIEF.md
# Control Endpoint Status Register

This block holds the handshake flags for a USB device's control endpoint (endpoint zero). Firmware sees them as one 8-bit register at a fixed index on a simple register access port. The USB protocol engine talks to the block through single-cycle event strobes. These mark a data packet received, an IN packet transmitted, a SETUP token arrived, an OUT token arrived, a STALL handshake sent, a control transaction ended and a status stage completed.

Each flag has its own ownership rule. Some bits are write-one strobes that clear a partner flag. Some flags only hardware can set. One flag is cleared by firmware writing a zero. The IN-ready flag withdraws itself when the host overwrites the pending packet with a new SETUP or OUT. The block raises a one-cycle interrupt pulse when a packet arrives and when a pending IN packet is consumed or cancelled. It also drives the stall request and the data-end marker back to the engine.

Register bit positions, LSB first: 0 out-ready, 1 in-ready, 2 stall-sent, 3 data-end, 4 setup-end, 5 stall-request, 6 serviced-out strobe, 7 serviced-setup-end strobe.

Top module: `ep0_ctrl_status`

## Requirements
- R1: After reset every flag is 0, the readback at index 0x11 is 0x00, and irq_o, stall_req_o and data_end_o are 0.
- R2: Reads at index 0x11 return the flags at the bit positions listed above. Reads at any other index return 0x00, and writes to any other index change nothing.
- R3: Bits 7 and 6 always read 0. A write with bit 7 = 1 clears setup-end (bit 4), and a write with bit 6 = 1 clears out-ready (bit 0).
- R4: When the engine signals the end of a control transaction, setup-end is set if data-end is 0 at that moment, and is left unchanged if data-end is 1.
- R5: A packet-received event sets out-ready. Firmware writes to bit 0 or bit 4 have no effect.
- R6: Writing 1 to bit 1 sets in-ready, and writing 0 leaves it unchanged. A transmit-done, SETUP or OUT event clears a set in-ready and raises the interrupt.
- R7: Writing 1 to bit 5 sets stall-request, which drives stall_req_o, and writing 0 leaves it unchanged. A stall-sent event clears stall-request and sets stall-sent (bit 2).
- R8: Stall-sent is cleared only by a write whose bit 2 is 0. A write with bit 2 = 1 leaves it set.
- R9: Writing 1 to bit 3 sets data-end, which drives data_end_o, and writing 0 leaves it unchanged. A status-stage-done event clears it.
- R10: When a hardware set event and a firmware clear hit the same flag in the same cycle, the flag ends up set.
- R11: irq_o is high for exactly the cycle after a packet-received event or an in-ready clear. Events that clear nothing raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register index for read and write |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| ev_rx_pkt_i | input | 1 | Data packet received |
| ev_tx_done_i | input | 1 | IN packet transmitted |
| ev_setup_i | input | 1 | SETUP token arrived |
| ev_out_i | input | 1 | OUT token arrived |
| ev_stall_sent_i | input | 1 | STALL handshake sent |
| ev_xfer_end_i | input | 1 | Control transaction ended |
| ev_status_done_i | input | 1 | Status stage completed |
| irq_o | output | 1 | Endpoint interrupt pulse |
| stall_req_o | output | 1 | Request to stall the current transfer |
| data_end_o | output | 1 | Last data packet marker |

## Verification
The hardest situations to reach are the same-cycle collisions. In these, an engine event sets a flag in the very cycle a firmware write clears it. Examples are a packet arriving while the serviced-out strobe is written, or a stall being sent while stall-sent is written to zero. A bench that only alternates writes and events never produces them. The stimulus task therefore drives an event strobe and a register write on the same clock edge. It then reads the register back to confirm the flag survived. It also drives transaction-end events with data-end both set and clear, to show that setup-end depends on data-end's state at that edge.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned N_FLAGS = 6;

  // flag index == register bit position
  localparam int unsigned F_OUT_RDY    = 0;
  localparam int unsigned F_IN_RDY     = 1;
  localparam int unsigned F_STALL_SENT = 2;
  localparam int unsigned F_DATA_END   = 3;
  localparam int unsigned F_SETUP_END  = 4;
  localparam int unsigned F_STALL_REQ  = 5;
  // write-only strobe positions
  localparam int unsigned B_SVC_OUT    = 6;
  localparam int unsigned B_SVC_SUE    = 7;

  typedef logic [N_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/ep0_wr_decode.sv
module ep0_wr_decode
  import ep0_pkg::*;
#(
  parameter int unsigned          ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]    REG_IDX = 'h11
) (
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              hit_o,
  output flag_vec_t         sw_set_o,
  output flag_vec_t         sw_clr_o
);
  logic wr_hit;
  logic unused_ro_bits;

  assign hit_o  = (reg_addr_i == REG_IDX);
  assign wr_hit = hit_o & reg_wr_i;
  // read-only positions are dropped on write
  assign unused_ro_bits = reg_wdata_i[F_OUT_RDY] ^ reg_wdata_i[F_SETUP_END];

  always_comb begin
    sw_set_o = '0;
    sw_clr_o = '0;
    sw_set_o[F_IN_RDY]     = wr_hit & reg_wdata_i[F_IN_RDY];
    sw_set_o[F_DATA_END]   = wr_hit & reg_wdata_i[F_DATA_END];
    sw_set_o[F_STALL_REQ]  = wr_hit & reg_wdata_i[F_STALL_REQ];
    sw_clr_o[F_OUT_RDY]    = wr_hit & reg_wdata_i[B_SVC_OUT];
    sw_clr_o[F_SETUP_END]  = wr_hit & reg_wdata_i[B_SVC_SUE];
    sw_clr_o[F_STALL_SENT] = wr_hit & ~reg_wdata_i[F_STALL_SENT];
  end
endmodule

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank
  import ep0_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  flag_vec_t set_i,
  input  flag_vec_t clr_i,
  output flag_vec_t q_o
);
  for (genvar k = 0; k < N_FLAGS; k++) begin : g_flag
    logic q;
    // set has priority so no event is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[k]) q <= 1'b1;
      else if (clr_i[k]) q <= 1'b0;
    end
    assign q_o[k] = q;

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
    a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[k] && clr_i[k]) |=> !q_o[k]);
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[k] && !clr_i[k]) |=> $stable(q_o[k]));
  end
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_pkt_i,
  input  logic in_rdy_i,
  input  logic in_cancel_i,
  output logic irq_o
);
  logic irq_d;
  assign irq_d = rx_pkt_i | (in_rdy_i & in_cancel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end

  a_r5_rx_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pkt_i |=> irq_o);
  a_r6_in_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rdy_i && in_cancel_i) |=> irq_o);
  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_pkt_i && !(in_rdy_i && in_cancel_i)) |=> !irq_o);
endmodule

// File: rtl/ep0_ctrl_status.sv
module ep0_ctrl_status
  import ep0_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_IDX = 'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              ev_rx_pkt_i,
  input  logic              ev_tx_done_i,
  input  logic              ev_setup_i,
  input  logic              ev_out_i,
  input  logic              ev_stall_sent_i,
  input  logic              ev_xfer_end_i,
  input  logic              ev_status_done_i,
  output logic              irq_o,
  output logic              stall_req_o,
  output logic              data_end_o
);
  logic      hit;
  logic      in_cancel;
  flag_vec_t sw_set, sw_clr, set_v, clr_v, flags;

  ep0_wr_decode #(.ADDR_W(ADDR_W), .REG_IDX(REG_IDX)) i_dec (
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .hit_o      (hit),
    .sw_set_o   (sw_set),
    .sw_clr_o   (sw_clr)
  );

  assign in_cancel = ev_tx_done_i | ev_setup_i | ev_out_i;

  // merge engine events with firmware strobes per flag ownership
  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_OUT_RDY]    = ev_rx_pkt_i;
    clr_v[F_OUT_RDY]    = sw_clr[F_OUT_RDY];
    set_v[F_IN_RDY]     = sw_set[F_IN_RDY];
    clr_v[F_IN_RDY]     = in_cancel;
    set_v[F_STALL_SENT] = ev_stall_sent_i;
    clr_v[F_STALL_SENT] = sw_clr[F_STALL_SENT];
    set_v[F_DATA_END]   = sw_set[F_DATA_END];
    clr_v[F_DATA_END]   = ev_status_done_i;
    set_v[F_SETUP_END]  = ev_xfer_end_i & ~flags[F_DATA_END];
    clr_v[F_SETUP_END]  = sw_clr[F_SETUP_END];
    set_v[F_STALL_REQ]  = sw_set[F_STALL_REQ];
    clr_v[F_STALL_REQ]  = ev_stall_sent_i;
  end

  ep0_flag_bank i_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (flags)
  );

  ep0_irq_gen i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_pkt_i   (ev_rx_pkt_i),
    .in_rdy_i   (flags[F_IN_RDY]),
    .in_cancel_i(in_cancel),
    .irq_o      (irq_o)
  );

  assign reg_rdata_o = hit ? {2'b00, flags} : '0;
  assign stall_req_o = flags[F_STALL_REQ];
  assign data_end_o  = flags[F_DATA_END];

  a_r4_setup_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_xfer_end_i && !data_end_o) |=> reg_rdata_o[F_SETUP_END] || !hit);
  a_r7_stall_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_req_o && ev_stall_sent_i && !sw_set[F_STALL_REQ]) |=> !stall_req_o);
  a_r9_data_end_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_status_done_i && !sw_set[F_DATA_END]) |=> !data_end_o);
  a_r3_strobe_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:6] == 2'b00);
endmodule

// File: tb/test_ep0_ctrl_status.sv
`timescale 1ns/1ps
module test_ep0_ctrl_status;
  localparam logic [7:0] IDX = 8'h11;
  // event vector: 0 rx,1 tx,2 setup,3 out,4 stall_sent,5 xfer_end,6 status_done
  localparam logic [6:0] E_RX = 7'h01, E_TX = 7'h02, E_SETUP = 7'h04, E_OUT = 7'h08,
                         E_STL = 7'h10, E_END = 7'h20, E_STAT = 7'h40;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = IDX, wdata = '0, rdata;
  logic       wr = 1'b0;
  logic [6:0] ev = '0;
  logic       irq, stall_req, data_end;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  ep0_ctrl_status i_ep0_ctrl_status (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ev_rx_pkt_i(ev[0]), .ev_tx_done_i(ev[1]), .ev_setup_i(ev[2]), .ev_out_i(ev[3]),
    .ev_stall_sent_i(ev[4]), .ev_xfer_end_i(ev[5]), .ev_status_done_i(ev[6]),
    .irq_o(irq), .stall_req_o(stall_req), .data_end_o(data_end)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one cycle of events and/or a write, then return past the capturing edge
  task automatic fire(input logic [6:0] e, input bit w, input logic [7:0] d,
                      input logic [7:0] a = IDX);
    @(negedge clk);
    ev = e; wr = w; wdata = d; addr = a;
    @(negedge clk);
    ev = '0; wr = 1'b0; wdata = '0; addr = IDX;
    #0.5;
  endtask

  task automatic idle();
    @(negedge clk);
    #0.5;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 outs", {5'b0, irq, stall_req, data_end}, 8'h00);
  endtask

  task automatic t_out_ready();
    fire(E_RX, 0, 8'h00);
    chk("R5 out_rdy set", rdata, 8'h01);
    chk("R5 irq", {7'b0, irq}, 8'h01);
    idle();
    chk("R11 irq single pulse", {7'b0, irq}, 8'h00);
    fire('0, 1, 8'h14);
    chk("R5 ro bits ignored", rdata, 8'h01);
    fire('0, 1, 8'h40);
    chk("R3 svc_out clears", rdata, 8'h00);
  endtask

  task automatic t_addr();
    fire('0, 1, 8'h2A, 8'h10);
    chk("R2 other index write ignored", rdata, 8'h00);
    chk("R2 stall_req after foreign write", {7'b0, stall_req}, 8'h00);
    fire('0, 1, 8'h02);
    @(negedge clk); addr = 8'h10; #0.5;
    chk("R2 other index reads zero", rdata, 8'h00);
    addr = IDX; #0.5;
    chk("R2 readback position", rdata, 8'h02);
    fire(E_TX, 0, 8'h00);
  endtask

  task automatic t_in_ready();
    fire('0, 1, 8'h02);
    chk("R6 in_rdy set", rdata, 8'h02);
    fire('0, 1, 8'h00);
    chk("R6 write 0 keeps in_rdy", rdata, 8'h02);
    fire(E_TX, 0, 8'h00);
    chk("R6 tx clears", rdata, 8'h00);
    chk("R6 tx irq", {7'b0, irq}, 8'h01);
    fire('0, 1, 8'h02);
    fire(E_SETUP, 0, 8'h00);
    chk("R6 setup cancels", {rdata[6:0], irq}, 8'h01);
    fire('0, 1, 8'h02);
    fire(E_OUT, 0, 8'h00);
    chk("R6 out cancels", {rdata[6:0], irq}, 8'h01);
    fire(E_TX, 0, 8'h00);
    chk("R11 no irq when already clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_stall();
    fire('0, 1, 8'h20);
    chk("R7 stall_req set", rdata, 8'h20);
    chk("R7 stall_req_o", {7'b0, stall_req}, 8'h01);
    fire('0, 1, 8'h04);
    chk("R7 write 0 keeps stall_req", rdata, 8'h20);
    fire(E_STL, 0, 8'h00);
    chk("R7 handoff", rdata, 8'h04);
    chk("R7 stall_req_o low", {7'b0, stall_req}, 8'h00);
    fire('0, 1, 8'h04);
    chk("R8 write 1 keeps stall_sent", rdata, 8'h04);
    idle();
    chk("R8 holds", rdata, 8'h04);
    fire('0, 1, 8'h00);
    chk("R8 write 0 clears", rdata, 8'h00);
  endtask

  task automatic t_data_end();
    fire('0, 1, 8'h08);
    chk("R9 data_end set", rdata, 8'h08);
    chk("R9 data_end_o", {7'b0, data_end}, 8'h01);
    fire('0, 1, 8'h00);
    chk("R9 write 0 keeps", rdata, 8'h08);
    fire(E_END, 0, 8'h00);
    chk("R4 no setup_end with data_end", rdata, 8'h08);
    fire(E_STAT, 0, 8'h00);
    chk("R9 status clears", rdata, 8'h00);
    fire(E_END, 0, 8'h00);
    chk("R4 setup_end set", rdata, 8'h10);
    fire('0, 1, 8'h80);
    chk("R3 svc_sue clears", rdata, 8'h00);
  endtask

  task automatic t_race();
    fire(E_RX, 1, 8'h44);
    chk("R10 rx beats svc_out", rdata, 8'h01);
    fire('0, 1, 8'h44);
    fire(E_END, 1, 8'h84);
    chk("R10 xfer_end beats svc_sue", rdata, 8'h10);
    fire('0, 1, 8'h84);
    fire(E_STL, 1, 8'h00);
    chk("R10 stall_sent beats write 0", rdata, 8'h04);
    fire('0, 1, 8'h00);
    chk("R10 cleanup", rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    t_reset();
    rst_n = 1'b1;
    t_out_ready();
    t_addr();
    t_in_ready();
    t_stall();
    t_data_end();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule